// File: doc/BRIEF.md
# Random Number Register Interface

This block sits between a random-word source and a processor bus. Random words arrive on a valid/data stream from the sampling path. Level error indications come from a health checker. The block holds one word at a time and shows software whether that word is ready and whether a seed or clock fault has been seen. Software reads the word through a read-only data register.

Software sets a run bit to start word capture. It can turn off clock-fault detection and can enable a single level interrupt. A live clock fault stops new words from being taken. A word that was already captured stays readable while the fault lasts. Reading the data register when no word is ready returns zero.

Top module: `rng_regs`

## Requirements
- R1: After reset the control register, the status register, `bus_rdata` and `irq` are all zero. No word is captured while the run bit (control bit 0) is 0.
- R2: Register offsets on `bus_addr` are 0x0 for control, 0x4 for status and 0x8 for data. Control bit 0 is run, bit 1 is interrupt enable, and bit 2 is clock-check-off, where 1 turns clock-fault detection off. Control reads back the written bits 2:0. Any other offset reads zero.
- R3: A read of the data register while the ready flag is 0 returns all zeros.
- R4: Status bit 0 is ready, bit 1 is live clock fault, bit 4 is the seed fault flag and bit 5 is the clock fault flag. The seed fault flag sets one cycle after `seed_fault` is high. Bits 4 and 5 stay set until software writes 0 to that bit of the status register. Writing 1 to either bit leaves it unchanged.
- R5: While clock-check-off is 0, a high `clk_fault` sets status bits 1 and 5 one cycle later. While status bit 1 is 1, incoming words are not captured. With clock-check-off at 1, `clk_fault` sets neither bit and does not block capture.
- R6: A word captured before a clock fault stays ready and reads back unchanged while the fault is live.
- R7: Read data appears on `bus_rdata` the cycle after the read strobe. A data read that returns a word clears the ready flag.
- R8: An incoming word is ignored while the previous word is still unread.
- R9: Clearing the run bit clears the ready flag on the next clock, and the data register then reads zero.
- R10: `irq` is 1 when the interrupt enable bit is set and any of ready, seed fault flag or clock fault flag is 1. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| rnd_valid | input | 1 | Incoming word is valid |
| rnd_word | input | 32 | Incoming random word |
| seed_fault | input | 1 | Seed error level from the health checker |
| clk_fault | input | 1 | Clock-too-slow level from the clock checker |
| run_out | output | 1 | Run bit, tells the sampling path to produce words |
| clk_chk_on | output | 1 | Clock checking is active |
| irq | output | 1 | Level interrupt |

## Verification
Every result here is due exactly one clock after its cause. A read strobe gives `bus_rdata` at the next edge. A captured word shows as ready at the next edge. A fault input sets its flag at the next edge. Clearing run drops ready one edge after the control write lands. The bench drives every input on the falling edge and holds it for one full cycle. It samples outputs on the following falling edge, so each check lands half a cycle after the edge that produced the result. Blocking by the live fault is tested only after a whole cycle has passed with `clk_fault` high, so the live flag is already registered when the word arrives.

// File: rtl/rng_regs.sv
module rng_regs #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rnd_valid,
  input  logic [DW-1:0] rnd_word,
  input  logic          seed_fault,
  input  logic          clk_fault,
  output logic          run_out,
  output logic          clk_chk_on,
  output logic          irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(4);
  localparam logic [AW-1:0] A_DATA = AW'(8);

  logic          run, ien, ckoff;
  logic          rdy, live, seedf, clkf;
  logic [DW-1:0] word;

  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_stat = bus_wr && bus_addr == A_STAT;
  wire rd_data = bus_rd && bus_addr == A_DATA;
  wire take    = run && rnd_valid && !rdy && !live;

  wire [DW-1:0] ctrl_v = DW'({ckoff, ien, run});
  wire [DW-1:0] stat_v = DW'({clkf, seedf, 2'b00, live, rdy});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run   <= 1'b0;
      ien   <= 1'b0;
      ckoff <= 1'b0;
    end else if (wr_ctrl) begin
      run   <= bus_wdata[0];
      ien   <= bus_wdata[1];
      ckoff <= bus_wdata[2];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live  <= 1'b0;
      seedf <= 1'b0;
      clkf  <= 1'b0;
    end else begin
      live  <= clk_fault && !ckoff;
      seedf <= (seedf && !(wr_stat && !bus_wdata[4])) || seed_fault;
      clkf  <= (clkf && !(wr_stat && !bus_wdata[5])) || (clk_fault && !ckoff);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      word <= '0;
    end else if (!run) begin
      rdy <= 1'b0;
    end else if (take) begin
      rdy  <= 1'b1;
      word <= rnd_word;
    end else if (rd_data) begin
      rdy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= ctrl_v;
        A_STAT:  bus_rdata <= stat_v;
        A_DATA:  bus_rdata <= rdy ? word : '0;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign run_out    = run;
  assign clk_chk_on = !ckoff;
  assign irq        = ien && (rdy || seedf || clkf);

  // R3
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !rdy) |=> bus_rdata == '0);

  // R5
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !rdy) |=> !rdy);

  // R6
  held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && live && run && !rd_data) |=> (rdy && $stable(word)));

  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && rdy) |=> !rdy);

  // R8
  unread_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy && run && !rd_data) |=> $stable(word));

  // R9
  stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !rdy);
endmodule

// File: tb/sim_rng_regs.sv
`timescale 1ns/1ps
module sim_rng_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rnd_valid = 1'b0;
  logic [31:0] rnd_word = '0;
  logic        seed_fault = 1'b0, clk_fault = 1'b0;
  logic        run_out, clk_chk_on, irq;
  int          errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  rng_regs u0 (.clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
               .rnd_valid, .rnd_word, .seed_fault, .clk_fault, .run_out, .clk_chk_on, .irq);

  localparam logic [31:0] VEC [8] = '{32'h0000_0001, 32'hFFFF_FFFF, 32'hA5A5_5A5A,
    32'h8000_0000, 32'h1234_5678, 32'hDEAD_BEEF, 32'h0F0F_F0F0, 32'h7FFF_FFFE};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [31:0] w);
    rnd_valid = 1'b1; rnd_word = w;
    @(negedge clk);
    rnd_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(4'h0, d); chk("R1 ctrl reset", d, 32'h0);
    rd(4'h4, d); chk("R1 status reset", d, 32'h0);
    chk("R1 irq reset", {31'b0, irq}, 32'h0);
    push(32'h1111_2222);
    rd(4'h4, d); chk("R1 no capture while stopped", d, 32'h0);
    rd(4'h8, d); chk("R3 data empty", d, 32'h0);
    // R2
    wr(4'h0, 32'h0000_0007);
    rd(4'h0, d); chk("R2 ctrl readback", d, 32'h7);
    chk("R2 clk_chk_on", {31'b0, clk_chk_on}, 32'h0);
    rd(4'hC, d); chk("R2 unmapped", d, 32'h0);
    wr(4'h0, 32'h0000_0001);
    chk("R2 run_out", {31'b0, run_out}, 32'h1);
    // table walk: R7 capture, read, clear
    foreach (VEC[i]) begin
      push(VEC[i]);
      rd(4'h4, d); chk("R7 ready set", d, 32'h1);
      rd(4'h8, d); chk("R7 data word", d, VEC[i]);
      rd(4'h4, d); chk("R7 ready cleared", d, 32'h0);
    end
    rd(4'h8, d); chk("R3 read after drain", d, 32'h0);
    // R8
    push(32'hAAAA_0001);
    push(32'hBBBB_0002);
    rd(4'h8, d); chk("R8 first word kept", d, 32'hAAAA_0001);
    // R5/R6
    push(32'hC0C0_0003);
    clk_fault = 1'b1;
    @(negedge clk);
    rd(4'h4, d); chk("R5 live and flag", d, 32'h23);
    rd(4'h8, d); chk("R6 held word", d, 32'hC0C0_0003);
    push(32'hDDDD_0004);
    rd(4'h4, d); chk("R5 blocked", d, 32'h22);
    rd(4'h8, d); chk("R5 blocked data zero", d, 32'h0);
    clk_fault = 1'b0;
    @(negedge clk);
    push(32'hEEEE_0005);
    rd(4'h8, d); chk("R5 resume capture", d, 32'hEEEE_0005);
    rd(4'h4, d); chk("R4 clk flag sticky", d, 32'h20);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h4, d); chk("R4 write one keeps", d, 32'h20);
    wr(4'h4, 32'h0);
    rd(4'h4, d); chk("R4 write zero clears", d, 32'h0);
    // R5 check off
    wr(4'h0, 32'h0000_0005);
    clk_fault = 1'b1;
    @(negedge clk);
    push(32'h5555_0006);
    rd(4'h4, d); chk("R5 check off flags", d, 32'h1);
    rd(4'h8, d); chk("R5 check off capture", d, 32'h5555_0006);
    clk_fault = 1'b0;
    // R4 seed / R10 irq
    wr(4'h0, 32'h0000_0003);
    chk("R10 irq idle", {31'b0, irq}, 32'h0);
    seed_fault = 1'b1;
    @(negedge clk);
    seed_fault = 1'b0;
    rd(4'h4, d); chk("R4 seed flag", d, 32'h10);
    chk("R10 irq seed", {31'b0, irq}, 32'h1);
    wr(4'h4, 32'h0);
    chk("R10 irq cleared", {31'b0, irq}, 32'h0);
    push(32'h6666_0007);
    chk("R10 irq ready", {31'b0, irq}, 32'h1);
    wr(4'h0, 32'h0000_0001);
    chk("R10 irq masked", {31'b0, irq}, 32'h0);
    // R9
    wr(4'h0, 32'h0);
    @(negedge clk);
    rd(4'h4, d); chk("R9 ready dropped", d, 32'h0);
    rd(4'h8, d); chk("R9 data zero", d, 32'h0);
    finish_run();
  end
endmodule